// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block is the byte engine of a master on a two-wire serial bus with one clock line and one data line, both open-drain. A controller above it hands over one command at a time: a START condition, a STOP condition, a byte write or a byte read. The engine turns the command into line activity and reports completion with a single-cycle `done_o` pulse. A write reports whether the addressed device acknowledged. A read returns the byte, and the engine answers it with either ACK or NACK as the controller chose.

Both lines are driven through output enables. An enable of 1 pulls the line low and an enable of 0 releases it. The engine also reads both lines back. Every clock period on the bus is built from four quarter-phases, and each quarter lasts `quarter_div_i + 1` system clocks. When the engine releases the clock line, it waits until the line is actually high before moving on. A slave can therefore stretch the clock for as long as it needs.

A START issued while the bus is still owned is a repeated START, so a new transfer can begin without a STOP first. Bus arbitration and address-level sequencing belong to the controller and are not part of this block.

Top module: `twi_byte_master`

## Requirements
- R1: `cmd_ready_o` is 1 exactly when no command is in progress. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_valid_i` has no effect while `cmd_ready_o` is 0. Command codes on `cmd_i` are 2'b00 START, 2'b01 STOP, 2'b10 WRITE and 2'b11 READ.
- R2: With no clock stretching, each quarter-phase lasts `quarter_div_i + 1` clocks. START and STOP each take 4 quarters and a byte takes 36 quarters (9 bit slots). `done_o` is high for one cycle, and it is first seen 4·(div+1) or 36·(div+1) clock edges after the accepting edge.
- R3: A write shifts out the 8 bits of `wr_data_i` most significant bit first, one bit per clock pulse, and the value is valid while the clock line is high.
- R4: During a byte, the data line changes only while the clock line is low. A data-line change while the clock is high happens only inside START and STOP.
- R5: On the ninth pulse of a write, the engine releases the data line and samples it. `ack_o` becomes 1 if the line was low and 0 if it was high, and it is valid from the `done_o` pulse.
- R6: A read releases the data line for 8 pulses and returns the sampled bits on `rd_data_o` (first bit = MSB) from the `done_o` pulse. On the ninth pulse the engine pulls the data line low if `rd_nack_i` was 0 at acceptance (ACK), or leaves it high if it was 1 (NACK).
- R7: START on a free bus pulls the data line low while the clock line is high, then pulls the clock low. It ends with both lines held low.
- R8: START issued after a byte (repeated START) first releases the data line while the clock is low, then releases the clock, then pulls the data line low while the clock is high. No STOP condition appears on the bus.
- R9: STOP pulls the data line low with the clock low, then releases the clock, then releases the data line while the clock is high. Both lines stay released afterwards, and both are released from reset.
- R10: While another device holds the clock line low after the engine has released it, the engine does not advance. It continues on the first edge at which the line is seen high with the quarter already elapsed.
- R11: Any number of bytes may follow one START without another START or a STOP between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quarter_div_i | input | DIV_W | Clocks per quarter-phase minus one |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | Command code (START/STOP/WRITE/READ) |
| wr_data_i | input | DATA_W | Byte to send on WRITE |
| rd_nack_i | input | 1 | On READ: 1 sends NACK, 0 sends ACK |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 1 | Acknowledge seen on the last write |
| rd_data_o | output | DATA_W | Byte from the last read |
| scl_i | input | 1 | Clock line level as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The bench sweeps all 256 write values with alternating slave acknowledge, and all 256 read values with a mix of ACK and NACK replies. A bit-order or acknowledge-polarity error shows up as a wrong captured byte or a wrong `ack_o`. Command lengths are measured for several divider values, so an off-by-one quarter count gives a wrong cycle count. A bus monitor counts START and STOP conditions and any data edge while the clock is high. An engine that issued a STOP before a repeated START, or moved the data line while the clock was high, would be counted there. A slave that stretches the clock for a fixed time must lengthen the byte by an exact amount, and a command pushed during a busy write must leave no STOP on the bus.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } twi_cmd_e;

  // output enables: 1 pulls the line low
  typedef struct packed {
    logic scl_oe;
    logic sda_oe;
  } twi_lines_t;

  localparam int unsigned QUARTERS = 4;

endpackage

// File: rtl/twi_quarter_timer.sv
module twi_quarter_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clear_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  // saturates at the limit so a stalled quarter stays elapsed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (cnt_q < div_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q >= div_i);

  a_r2_tick_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && tick_o) |=> (tick_o || (div_i != $past(div_i))));

endmodule

// File: rtl/twi_line_table.sv
module twi_line_table
  import twi_pkg::*;
(
  input  twi_cmd_e   op_i,
  input  logic [1:0] phase_i,
  input  logic       bit_val_i,
  input  twi_lines_t cur_i,
  output twi_lines_t lines_o
);

  always_comb begin
    lines_o = cur_i;
    unique case (op_i)
      CMD_START: begin
        unique case (phase_i)
          2'd0: lines_o = '{scl_oe: cur_i.scl_oe, sda_oe: 1'b0};
          2'd1: lines_o = '{scl_oe: 1'b0, sda_oe: 1'b0};
          2'd2: lines_o = '{scl_oe: 1'b0, sda_oe: 1'b1};
          default: lines_o = '{scl_oe: 1'b1, sda_oe: 1'b1};
        endcase
      end
      CMD_STOP: begin
        unique case (phase_i)
          2'd0: lines_o = '{scl_oe: 1'b1, sda_oe: 1'b1};
          2'd1: lines_o = '{scl_oe: 1'b0, sda_oe: 1'b1};
          default: lines_o = '{scl_oe: 1'b0, sda_oe: 1'b0};
        endcase
      end
      default: begin
        // byte slot: clock low in quarters 0 and 3, data fixed for the slot
        lines_o.sda_oe = !bit_val_i;
        lines_o.scl_oe = (phase_i == 2'd0) || (phase_i == 2'd3);
      end
    endcase
  end

endmodule

// File: rtl/twi_shifter.sv
module twi_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sda_i,
  output logic              tx_msb_d_o,
  output logic [DATA_W-1:0] rx_data_o
);

  logic [DATA_W-1:0] tx_q, tx_d, rx_q;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = load_data_i;
    else if (shift_i) tx_d = {tx_q[DATA_W-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '1;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      if (sample_i) rx_q <= {rx_q[DATA_W-2:0], sda_i};
    end
  end

  assign tx_msb_d_o = tx_d[DATA_W-1];
  assign rx_data_o  = rx_q;

endmodule

// File: rtl/twi_byte_master.sv
module twi_byte_master
  import twi_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  quarter_div_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_nack_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);

  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);
  localparam logic [1:0] LAST_Q = 2'(QUARTERS - 1);

  logic              busy_q, busy_d;
  twi_cmd_e          op_q, op_d;
  logic [1:0]        phase_q, phase_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              nack_q, nack_d;
  twi_lines_t        lines_q, lines_d, table_lines;
  logic              done_q, ack_q;
  logic [DATA_W-1:0] rd_q, rx_data;

  logic tick, accept, stall, advance, byte_op, ack_slot;
  logic finish, bit_step, sample, tx_msb_d, bit_val_d;

  assign accept   = cmd_valid_i && !busy_q;
  assign byte_op  = (op_q == CMD_WRITE) || (op_q == CMD_READ);
  assign ack_slot = (bit_q == ACK_SLOT);
  // quarter 1 is the released-clock quarter: wait for the line to be high
  assign stall    = (phase_q == 2'd1) && !scl_i;
  assign advance  = busy_q && tick && !stall;
  assign finish   = advance && (phase_q == LAST_Q) && (!byte_op || ack_slot);
  assign bit_step = advance && (phase_q == LAST_Q) && byte_op && !ack_slot;
  assign sample   = advance && (phase_q == 2'd2) && byte_op;

  twi_quarter_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (quarter_div_i),
    .clear_i (accept || advance),
    .tick_o  (tick)
  );

  twi_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (wr_data_i),
    .shift_i     (bit_step),
    .sample_i    (sample && !ack_slot),
    .sda_i       (sda_i),
    .tx_msb_d_o  (tx_msb_d),
    .rx_data_o   (rx_data)
  );

  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    nack_d  = nack_q;
    if (accept) begin
      busy_d  = 1'b1;
      op_d    = twi_cmd_e'(cmd_i);
      phase_d = 2'd0;
      bit_d   = '0;
      nack_d  = rd_nack_i;
    end else if (advance) begin
      if (finish) begin
        busy_d  = 1'b0;
        phase_d = 2'd0;
      end else if (bit_step) begin
        bit_d   = bit_q + 1'b1;
        phase_d = 2'd0;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  // line levels are computed for the state being entered, then registered
  always_comb begin
    if (bit_d == ACK_SLOT) bit_val_d = (op_d == CMD_WRITE) ? 1'b1 : nack_d;
    else                   bit_val_d = (op_d == CMD_WRITE) ? tx_msb_d : 1'b1;
  end

  twi_line_table i_table (
    .op_i      (op_d),
    .phase_i   (phase_d),
    .bit_val_i (bit_val_d),
    .cur_i     (lines_q),
    .lines_o   (table_lines)
  );

  assign lines_d = (busy_d && (accept || advance)) ? table_lines : lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      op_q    <= CMD_STOP;
      phase_q <= 2'd0;
      bit_q   <= '0;
      nack_q  <= 1'b0;
      lines_q <= '0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      op_q    <= op_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      nack_q  <= nack_d;
      lines_q <= lines_d;
      done_q  <= finish;
      if (sample && ack_slot && (op_q == CMD_WRITE)) ack_q <= !sda_i;
      if (finish && (op_q == CMD_READ)) rd_q <= rx_data;
    end
  end

  assign cmd_ready_o = !busy_q;
  assign done_o      = done_q;
  assign ack_o       = ack_q;
  assign rd_data_o   = rd_q;
  assign scl_oe_o    = lines_q.scl_oe;
  assign sda_oe_o    = lines_q.sda_oe;

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_sda_still_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && byte_op && !lines_q.scl_oe) |=> $stable(lines_q.sda_oe));

  a_r9_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == CMD_STOP)) |-> (!scl_oe_o && !sda_oe_o));

  a_r10_stretch_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (phase_q == 2'd1) && !scl_i) |=> (busy_q && (phase_q == 2'd1)));

endmodule

// File: tb/test_twi_byte_master.sv
module test_twi_byte_master;

  localparam int DIV_W = 4;
  localparam logic [1:0] C_START = 2'b00, C_STOP = 2'b01, C_WR = 2'b10, C_RD = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [DIV_W-1:0] div = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = C_START;
  logic [7:0] wdata = '0;
  logic rd_nack = 1'b0;
  wire cmd_ready, done, ack, scl_oe, sda_oe;
  wire [7:0] rd_data;

  // bus and slave model
  logic slave_hold = 1'b0;
  logic slave_ack = 1'b0;
  int mode = 0;  // 0 idle, 1 write target, 2 read source
  logic [7:0] rd_byte = '0;
  logic [3:0] bcnt = 4'd0;
  logic armed = 1'b0;
  logic cond_cmd = 1'b1;
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  logic [7:0] mon_byte = '0;
  logic mon_ack = 1'b0;
  int starts = 0, stops = 0, bad_sda = 0;

  wire scl_line = !scl_oe && !slave_hold;
  wire slave_sda_low = ((mode == 2) && (bcnt < 4'd8) && !rd_byte[3'd7 - bcnt[2:0]]) ||
                       ((mode == 1) && (bcnt == 4'd8) && slave_ack);
  wire sda_line = !sda_oe && !slave_sda_low;

  twi_byte_master #(.DIV_W(DIV_W), .DATA_W(8)) i_twi_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .quarter_div_i(div),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wr_data_i(wdata), .rd_nack_i(rd_nack),
    .cmd_ready_o(cmd_ready), .done_o(done), .ack_o(ack), .rd_data_o(rd_data),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always @(scl_line or sda_line) begin
    if (rst_n) begin
      if (scl_prev && scl_line && sda_prev && !sda_line) begin
        starts++; bcnt = 4'd0; armed = 1'b1;
      end
      if (scl_prev && scl_line && !sda_prev && sda_line) stops++;
      if (scl_prev && scl_line && (sda_line != sda_prev) && !cond_cmd) bad_sda++;
      if (scl_prev && !scl_line) begin
        if (armed) armed = 1'b0;
        else bcnt = (bcnt == 4'd8) ? 4'd0 : bcnt + 4'd1;
      end
      if (!scl_prev && scl_line) begin
        if (bcnt < 4'd8) mon_byte = {mon_byte[6:0], sda_line};
        else mon_ack = sda_line;
      end
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, input logic nk,
                         input int s, input int h, input bit poke, output int cyc);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd = c; wdata = d; rd_nack = nk; cmd_valid = 1'b1;
    @(posedge clk);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      cmd_valid = poke && (cyc >= 3) && (cyc < 6);
      if (poke) cmd = C_STOP;
      slave_hold = (h > 0) && (cyc >= s) && (cyc < s + h);
      if (done) break;
    end
    cmd_valid = 1'b0;
    slave_hold = 1'b0;
  endtask

  function automatic int q(input int n);
    return n * (int'(div) + 1) + 1;
  endfunction

  task automatic do_start(input string tag);
    int cyc, s0, p0;
    cond_cmd = 1'b1; mode = 0; s0 = starts; p0 = stops;
    run_cmd(C_START, 8'h00, 1'b0, 0, 0, 1'b0, cyc);
    chk(cyc == q(4), "R2", "START length", cyc, q(4));
    chk(starts == s0 + 1, tag, "START conditions seen", starts - s0, 1);
    chk(stops == p0, tag, "no STOP during START", stops - p0, 0);
    chk(scl_oe && sda_oe, tag, "both lines held low after START", {scl_oe, sda_oe}, 3);
    cond_cmd = 1'b0;
  endtask

  task automatic do_stop();
    int cyc, p0;
    cond_cmd = 1'b1; mode = 0; p0 = stops;
    run_cmd(C_STOP, 8'h00, 1'b0, 0, 0, 1'b0, cyc);
    chk(cyc == q(4), "R2", "STOP length", cyc, q(4));
    chk(stops == p0 + 1, "R9", "STOP conditions seen", stops - p0, 1);
    chk(!scl_oe && !sda_oe && scl_line && sda_line, "R9", "lines released after STOP",
        {scl_line, sda_line}, 3);
  endtask

  task automatic do_write(input logic [7:0] v, input logic sa, input bit timed);
    int cyc;
    mode = 1; slave_ack = sa;
    run_cmd(C_WR, v, 1'b0, 0, 0, 1'b0, cyc);
    if (timed) chk(cyc == q(36), "R2", "WRITE length", cyc, q(36));
    chk(mon_byte == v, "R3", "byte on bus", mon_byte, v);
    chk(ack == sa, "R5", "ack_o", ack, sa);
    if (!sa) chk(mon_ack == 1'b1, "R5", "data released on ninth pulse", mon_ack, 1);
  endtask

  task automatic do_read(input logic [7:0] v, input logic nk);
    int cyc;
    mode = 2; rd_byte = v;
    run_cmd(C_RD, 8'h00, nk, 0, 0, 1'b0, cyc);
    chk(cyc == q(36), "R2", "READ length", cyc, q(36));
    chk(rd_data == v, "R6", "read byte", rd_data, v);
    chk(mon_ack == nk, "R6", "ACK/NACK level on ninth pulse", mon_ack, nk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cyc, s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R9", "lines released from reset", {scl_oe, sda_oe}, 0);
    chk(cmd_ready && !done, "R1", "ready and no done after reset", {cmd_ready, done}, 2);
    cond_cmd = 1'b0;

    // divider sweep: START, one write, STOP
    for (int d = 0; d < 4; d++) begin
      div = DIV_W'(d);
      do_start("R7");
      do_write(8'hA5, 1'b1, 1'b1);
      do_stop();
    end

    // every write value, one START for all of them
    div = '0;
    do_start("R7");
    s0 = starts; p0 = stops;
    for (int v = 0; v < 256; v++) do_write(8'(v), v[0], v[4:0] == 5'd0);
    chk(starts == s0 && stops == p0, "R11", "256 bytes with no START/STOP between",
        starts - s0 + stops - p0, 0);
    do_start("R8");
    chk(stops == p0, "R8", "repeated START with no STOP", stops - p0, 0);

    // every read value, ACK/NACK mix, repeated START after a NACKed read
    div = DIV_W'(1);
    for (int v = 0; v < 256; v++) do_read(8'(v), (v % 3) == 0);
    do_read(8'h3C, 1'b1);
    p0 = stops;
    do_start("R8");
    chk(stops == p0, "R8", "repeated START after read, no STOP", stops - p0, 0);
    do_stop();

    // clock stretching during the first bit slot
    div = DIV_W'(2);
    do_start("R7");
    mode = 1; slave_ack = 1'b1;
    run_cmd(C_WR, 8'h96, 1'b0, 2, 40, 1'b0, cyc);
    chk(cyc == q(36) + 42 - 2 * (int'(div) + 1), "R10", "stretched WRITE length",
        cyc, q(36) + 42 - 2 * (int'(div) + 1));
    chk(mon_byte == 8'h96, "R10", "byte intact after stretch", mon_byte, 8'h96);
    chk(ack == 1'b1, "R10", "ack after stretch", ack, 1);

    // command pushed while busy is ignored
    p0 = stops;
    mode = 1; slave_ack = 1'b0;
    run_cmd(C_WR, 8'h5A, 1'b0, 0, 0, 1'b1, cyc);
    chk(cyc == q(36), "R1", "write length with ignored command", cyc, q(36));
    chk(stops == p0, "R1", "no STOP from ignored command", stops - p0, 0);
    chk(mon_byte == 8'h5A, "R1", "byte intact with ignored command", mon_byte, 8'h5A);
    @(negedge clk);
    chk(cmd_ready && !done, "R1", "idle after ignored command", {cmd_ready, done}, 2);
    do_stop();

    chk(bad_sda == 0, "R4", "data edges while clock high outside START/STOP", bad_sda, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule